// File: doc/BRIEF.md
# Dope-Vector Subscript Displacement Unit

This block turns a list of subscripts for a multidimensional array into a single displacement from the array's origin. The shape of the array lives in memory as a dope vector, with one entry per dimension. Each entry holds three 32-bit words: lowest legal subscript, highest legal subscript, and stride. Software gives one command per subscript. The subscript value is presented on a modifier input along with the command.

A first-subscript command does three things. It latches the dope-vector pointer, selects dimension 0 and starts a new sum. Each following-subscript command moves to the next dimension's entry and adds that dimension's share to the sum. Every subscript is range-checked against its dimension. A subscript out of range raises a one-cycle interrupt and leaves the sum and the dimension position as they were.

The three words of an entry are fetched in turn through a request/valid read port. The unit reports busy from the time it accepts a command until the result is committed. When the last subscript is done, the displacement output is ready for the element access, which is outside this block.

Top module: `subscript_unit`

## Requirements
- R1: After reset, busy, rd_req, bound_irq and acc_ovf are 0 and disp is 0.
- R2: An accepted command reads its dimension entry as three words at word addresses base+3*dim+0 (lower bound), +1 (upper bound) and +2 (stride). rd_req and rd_addr are held steady until rd_valid is seen for each word.
- R3: A first-subscript command latches dv_ptr as base and selects dimension 0. If the subscript is in range, disp becomes (subscript - lower) * stride.
- R4: A following-subscript command uses dimension current+1. If the subscript is in range, it adds (subscript - lower) * stride to disp, and that dimension becomes current.
- R5: The range check is inclusive, lower <= subscript <= upper, with both comparisons done on signed 32-bit values.
- R6: On a range violation, bound_irq is 1 for exactly one cycle, and disp and acc_ovf keep their values. For a following-subscript command the current dimension does not advance. A rejected first-subscript command still loads the base and selects dimension 0.
- R7: busy rises the cycle after a command is accepted in idle and falls when the result is committed. disp only changes at that commit. Commands that arrive while busy is 1 are ignored.
- R8: The product keeps only the low 32 bits of (subscript - lower) * stride.
- R9: acc_ovf is set when adding a following-subscript share overflows in signed terms, and it stays set. A first-subscript command that passes the range check clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_first | input | 1 | First-subscript command (wins over cmd_next) |
| cmd_next | input | 1 | Following-subscript command |
| dv_ptr | input | ADDR_W | Dope-vector base word address |
| subscript | input | DATA_W | Subscript value from the modifier |
| rd_req | output | 1 | Read request to memory |
| rd_addr | output | ADDR_W | Read word address |
| rd_valid | input | 1 | Read data valid |
| rd_data | input | DATA_W | Read data |
| busy | output | 1 | Command in progress |
| disp | output | DATA_W | Accumulated displacement |
| bound_irq | output | 1 | One-cycle bound-violation interrupt |
| acc_ovf | output | 1 | Sticky accumulation overflow flag |

## Verification
A wrong dimension position shows up on rd_addr in the first cycle after the next command is accepted. A wrong word counter, or a triple captured into the wrong register, shows up as a wrong sum, a false interrupt or a missed interrupt when that command commits. Signed-compare and inclusive-edge errors need subscripts exactly on the bounds and negative values that compare differently when treated as unsigned. Each of these is settled at the cycle busy falls. A command sneaking in while busy shows at the following command's fetch address.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  localparam int TRIPLE_WORDS = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2
  } ssu_state_t;
endpackage

// File: rtl/ssu_fetch.sv
module ssu_fetch
  import ssu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int DIM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [DIM_W-1:0]  dim_sel,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] lo,
  output logic [DATA_W-1:0] hi,
  output logic [DATA_W-1:0] stride,
  output logic              done
);
  localparam logic [1:0] LAST_WORD = 2'(TRIPLE_WORDS - 1);

  logic [1:0]        word_q, word_d;
  logic [DATA_W-1:0] trip_q [TRIPLE_WORDS];
  logic [ADDR_W-1:0] entry_off;

  // entry offset = 3 * dim
  assign entry_off = ADDR_W'(dim_sel) + ADDR_W'({dim_sel, 1'b0});
  assign rd_addr   = base_addr + entry_off + ADDR_W'(word_q);
  assign rd_req    = enable;
  assign done      = enable && rd_valid && (word_q == LAST_WORD);

  always_comb begin
    word_d = word_q;
    if (!enable) begin
      word_d = '0;
    end else if (rd_valid) begin
      word_d = (word_q == LAST_WORD) ? 2'd0 : word_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  for (genvar g = 0; g < TRIPLE_WORDS; g++) begin : g_word
    logic cap_en;
    assign cap_en = enable && rd_valid && (word_q == 2'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      trip_q[g] <= '0;
      else if (cap_en) trip_q[g] <= rd_data;
    end
  end

  assign lo     = trip_q[0];
  assign hi     = trip_q[1];
  assign stride = trip_q[2];
endmodule

// File: rtl/ssu_arith.sv
module ssu_arith #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] sub,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] stride,
  input  logic [DATA_W-1:0] acc,
  input  logic              first,
  output logic              in_range,
  output logic [DATA_W-1:0] sum,
  output logic              add_ovf
);
  logic [DATA_W-1:0] diff, term, addend;

  assign in_range = ($signed(sub) >= $signed(lo)) && ($signed(sub) <= $signed(hi));
  assign diff     = sub - lo;
  assign term     = diff * stride;           // low DATA_W bits kept
  assign addend   = first ? '0 : acc;
  assign sum      = addend + term;
  assign add_ovf  = (addend[DATA_W-1] == term[DATA_W-1]) &&
                    (sum[DATA_W-1] != addend[DATA_W-1]);
endmodule

// File: rtl/subscript_unit.sv
module subscript_unit
  import ssu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int DIM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_first,
  input  logic              cmd_next,
  input  logic [ADDR_W-1:0] dv_ptr,
  input  logic [DATA_W-1:0] subscript,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic [DATA_W-1:0] disp,
  output logic              bound_irq,
  output logic              acc_ovf
);
  ssu_state_t        state_q, state_d;
  logic              first_q, first_d;
  logic [DATA_W-1:0] sub_q, sub_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [DIM_W-1:0]  dim_q, dim_d, dim_sel;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic              ovf_q, ovf_d;
  logic              irq_q, irq_d;
  logic              cmd_en, commit_en;

  logic [DATA_W-1:0] t_lo, t_hi, t_stride, sum;
  logic              fetch_done, in_range, add_ovf;

  assign dim_sel = first_q ? '0 : dim_q + DIM_W'(1);

  ssu_fetch #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIM_W(DIM_W)) i_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (state_q == ST_FETCH),
    .base_addr (base_q),
    .dim_sel   (dim_sel),
    .rd_req    (rd_req),
    .rd_addr   (rd_addr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .lo        (t_lo),
    .hi        (t_hi),
    .stride    (t_stride),
    .done      (fetch_done)
  );

  ssu_arith #(.DATA_W(DATA_W)) i_arith (
    .sub      (sub_q),
    .lo       (t_lo),
    .hi       (t_hi),
    .stride   (t_stride),
    .acc      (acc_q),
    .first    (first_q),
    .in_range (in_range),
    .sum      (sum),
    .add_ovf  (add_ovf)
  );

  assign cmd_en    = (state_q == ST_IDLE) && (cmd_first || cmd_next);
  assign commit_en = (state_q == ST_EXEC) && in_range;

  // next-state
  always_comb begin
    state_d = state_q;
    first_d = first_q;
    sub_d   = sub_q;
    base_d  = base_q;
    dim_d   = dim_q;
    acc_d   = acc_q;
    ovf_d   = ovf_q;
    irq_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_en) begin
          state_d = ST_FETCH;
          first_d = cmd_first;
          sub_d   = subscript;
          if (cmd_first) begin
            base_d = dv_ptr;
            dim_d  = '0;
          end
        end
      end
      ST_FETCH: begin
        if (fetch_done) state_d = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_IDLE;
        if (in_range) begin
          acc_d = sum;
          dim_d = dim_sel;
          ovf_d = first_q ? 1'b0 : (ovf_q | add_ovf);
        end else begin
          irq_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      first_q <= 1'b0;
      sub_q   <= '0;
      base_q  <= '0;
      dim_q   <= '0;
      acc_q   <= '0;
      ovf_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      irq_q   <= irq_d;
      if (cmd_en) begin
        first_q <= first_d;
        sub_q   <= sub_d;
        base_q  <= base_d;
      end
      if (cmd_en || commit_en) dim_q <= dim_d;
      if (commit_en) begin
        acc_q <= acc_d;
        ovf_q <= ovf_d;
      end
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign disp      = acc_q;
  assign bound_irq = irq_q;
  assign acc_ovf   = ovf_q;
endmodule

// File: rtl/ssu_checker.sv
module ssu_checker #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_first,
  input logic              cmd_next,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              busy,
  input logic [DATA_W-1:0] disp,
  input logic              bound_irq,
  input logic              acc_ovf
);
  a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_valid |=> rd_req && $stable(rd_addr));

  a_r7_req_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> busy);

  a_r7_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (cmd_first || cmd_next) |=> busy);

  a_r7_disp_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> $stable(disp));

  a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    bound_irq |=> !bound_irq);

  a_r6_disp_kept: assert property (@(posedge clk) disable iff (!rst_n)
    bound_irq |-> disp == $past(disp));

  a_r9_ovf_commit_only: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> $stable(acc_ovf));
endmodule

bind subscript_unit ssu_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ssu_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_first (cmd_first),
  .cmd_next  (cmd_next),
  .rd_req    (rd_req),
  .rd_valid  (rd_valid),
  .rd_addr   (rd_addr),
  .busy      (busy),
  .disp      (disp),
  .bound_irq (bound_irq),
  .acc_ovf   (acc_ovf)
);

// File: tb/test_subscript_unit.sv
`timescale 1ns/1ps
module test_subscript_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_first, cmd_next;
  logic [7:0]  dv_ptr;
  logic [31:0] subscript;
  logic        rd_req, rd_valid;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;
  logic        busy, bound_irq, acc_ovf;
  logic [31:0] disp;
  logic [31:0] mem [0:63];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  subscript_unit i_subscript_unit (
    .clk(clk), .rst_n(rst_n), .cmd_first(cmd_first), .cmd_next(cmd_next),
    .dv_ptr(dv_ptr), .subscript(subscript), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .disp(disp),
    .bound_irq(bound_irq), .acc_ovf(acc_ovf)
  );

  // memory: valid one cycle after request, then drops for a cycle
  always @(posedge clk) begin
    if (!rst_n) rd_valid <= 1'b0;
    else        rd_valid <= rd_req && !rd_valid;
    rd_data <= mem[rd_addr[5:0]];
  end

  // fields: [74] first, [73:42] subscript, [41:34] address, [33:2] disp, [1] irq, [0] ovf
  localparam int NV = 12;
  localparam logic [74:0] VEC [NV] = '{
    {1'b1, 32'd0,          8'd4,  32'd8,   1'b0, 1'b0},
    {1'b0, 32'd9,          8'd7,  32'd296, 1'b0, 1'b0},
    {1'b0, 32'd3,          8'd10, 32'd296, 1'b0, 1'b0},
    {1'b1, 32'hFFFFFFFE,   8'd4,  32'd0,   1'b0, 1'b0},
    {1'b0, 32'd10,         8'd7,  32'd0,   1'b1, 1'b0},
    {1'b0, 32'd1,          8'd7,  32'd32,  1'b0, 1'b0},
    {1'b0, 32'd4,          8'd10, 32'd32,  1'b1, 1'b0},
    {1'b1, 32'd5,          8'd4,  32'd28,  1'b0, 1'b0},
    {1'b1, 32'd6,          8'd4,  32'd28,  1'b1, 1'b0},
    {1'b0, 32'd2,          8'd7,  32'd92,  1'b0, 1'b0},
    {1'b1, 32'hFFFFFFFD,   8'd4,  32'd92,  1'b1, 1'b0},
    {1'b1, 32'hFFFFFFFF,   8'd4,  32'd4,   1'b0, 1'b0}
  };

  function automatic string row_tag(int i);
    case (i)
      0:  return "R3 first subscript";
      1:  return "R4 next subscript";
      2:  return "R5 lower equals upper";
      3:  return "R5 lower edge negative";
      4:  return "R6 upper violation";
      5:  return "R6 dimension kept";
      6:  return "R6 third dimension violation";
      7:  return "R5 upper edge";
      8:  return "R6 first violation";
      9:  return "R4 after rejected first";
      10: return "R6 below lower";
      default: return "R5 signed compare";
    endcase
  endfunction

  task automatic check(input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic run_cmd(input bit first, input logic [31:0] sub,
                         input logic [7:0] exp_addr, input logic [31:0] exp_disp,
                         input bit exp_irq, input bit exp_ovf, input bit poke,
                         input string tag);
    @(negedge clk);
    cmd_first = first;
    cmd_next  = !first;
    subscript = sub;
    @(negedge clk);
    cmd_first = 1'b0;
    cmd_next  = poke;
    subscript = 32'h5A5A5A5A;
    check(rd_req === 1'b1 && rd_addr === exp_addr, {tag, " R2 fetch address"},
          {24'd0, rd_addr}, {24'd0, exp_addr});
    @(negedge clk);
    cmd_next = 1'b0;
    while (busy) @(negedge clk);
    check(disp === exp_disp, {tag, " disp"}, disp, exp_disp);
    check(bound_irq === exp_irq, {tag, " bound_irq"}, {31'd0, bound_irq}, {31'd0, exp_irq});
    check(acc_ovf === exp_ovf, {tag, " acc_ovf"}, {31'd0, acc_ovf}, {31'd0, exp_ovf});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual busy expected idle");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'd0;
    mem[4]  = 32'hFFFFFFFE; mem[5]  = 32'd5;          mem[6]  = 32'd4;
    mem[7]  = 32'd0;        mem[8]  = 32'd9;          mem[9]  = 32'd32;
    mem[10] = 32'd3;        mem[11] = 32'd3;          mem[12] = 32'd1000;
    mem[20] = 32'd0;        mem[21] = 32'h7FFFFFFF;   mem[22] = 32'd1;
    mem[23] = 32'd0;        mem[24] = 32'h7FFFFFFF;   mem[25] = 32'h00010000;
    rst_n = 1'b0; cmd_first = 1'b0; cmd_next = 1'b0;
    dv_ptr = 8'd4; subscript = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy === 1'b0 && rd_req === 1'b0, "R1 idle after reset", {30'd0, busy, rd_req}, 32'd0);
    check(disp === 32'd0, "R1 disp after reset", disp, 32'd0);
    check(bound_irq === 1'b0 && acc_ovf === 1'b0, "R1 flags after reset",
          {30'd0, bound_irq, acc_ovf}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      run_cmd(VEC[i][74], VEC[i][73:42], VEC[i][41:34], VEC[i][33:2],
              VEC[i][1], VEC[i][0], 1'b0, row_tag(i));
    end

    // R9 overflow and R8 product wrap on a second dope vector
    dv_ptr = 8'd20;
    run_cmd(1'b1, 32'h7FFFFFFF, 8'd20, 32'h7FFFFFFF, 1'b0, 1'b0, 1'b0, "R3 new base");
    run_cmd(1'b0, 32'd1,        8'd23, 32'h8000FFFF, 1'b0, 1'b1, 1'b0, "R9 overflow set");
    run_cmd(1'b1, 32'd0,        8'd20, 32'd0,        1'b0, 1'b0, 1'b0, "R9 overflow cleared");
    run_cmd(1'b0, 32'h00010001, 8'd23, 32'h00010000, 1'b0, 1'b0, 1'b0, "R8 low product bits");

    // R7 command during busy ignored: next command still fetches dimension 1
    run_cmd(1'b1, 32'd3, 8'd20, 32'd3, 1'b0, 1'b0, 1'b1, "R7 poke during busy");
    run_cmd(1'b0, 32'd0, 8'd23, 32'd3, 1'b0, 1'b0, 1'b0, "R7 dimension after ignored poke");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule